// File: doc/BRIEF.md
# Arithmetic and Logic Unit with Condition Flags

This block is the integer execution unit of a 32-bit load/store datapath. Each cycle it takes two operands, a 4-bit operation code and an incoming carry bit. It returns a result right away, with no register in the path. It covers three bitwise operations, six add and subtract forms and three shifts. The subtract forms include reverse subtraction, which takes B minus A, and forms that fold in the incoming carry.

The block also derives four condition flags from each operation: zero, negative, signed overflow and carry. A flag register stores them at the clock edge, but only when the instruction asks for condition codes to be set. An operation code outside the defined set returns zero and raises an illegal-operation output. Such a code never touches the stored flags.

Top module: `cc_alu`

## Requirements
- R1: Operation codes 0, 1 and 2 give A AND B, A OR B and A XOR B. They leave flag V and flag C at 0.
- R2: For every defined operation code (0 to 11), the stored zero flag is set exactly when the result is all zeros. The stored negative flag equals result bit 31.
- R3: Code 3 gives A+B and code 4 gives A+B+carryIn. Flag C is the unsigned carry out of bit 31. Flag V reports signed two's-complement overflow.
- R4: Code 5 gives A−B. Flag C is set when no unsigned borrow occurs (A ≥ B). Flag V reports signed overflow.
- R5: Code 6 gives A−B+carryIn. Flag C is set when A+carryIn ≥ B taken as unsigned. Flag V is set when the true signed value does not fit in 32 bits.
- R6: Code 7 gives B−A and code 8 gives B−A+carryIn. The flags follow the same not-borrow and signed-overflow rules, with B as the minuend.
- R7: Code 9 is a logical right shift, code 10 an arithmetic right shift that copies bit 31 of A, and code 11 a left shift. A is the value shifted and B[4:0] is the amount, so an amount of 0 returns A unchanged. V and C are 0 for all three.
- R8: The stored flags load at a rising clock edge only when setFlags is 1 and the code is defined. Otherwise they keep their value.
- R9: Codes 12 to 15 give a result of 0, drive illegalOp to 1 and leave the stored flags unchanged. illegalOp is 0 for codes 0 to 11.
- R10: An active-low asynchronous reset clears all four stored flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rstN | input | 1 | Asynchronous active-low reset |
| opA | input | 32 | Operand A, which is also the value to shift |
| opB | input | 32 | Operand B, whose low 5 bits are the shift amount |
| opSel | input | 4 | Operation code |
| carryIn | input | 1 | Incoming carry for codes 4, 6 and 8 |
| setFlags | input | 1 | Request to store the flags of this operation |
| result | output | 32 | Combinational result |
| illegalOp | output | 1 | Set for an undefined operation code |
| flagZero | output | 1 | Stored zero flag |
| flagNeg | output | 1 | Stored negative flag |
| flagOvf | output | 1 | Stored signed-overflow flag |
| flagCarry | output | 1 | Stored carry / not-borrow flag |

## Verification
The assertions assume that opSel, opA, opB and setFlags are known and do not change around the rising edge where they are sampled. They also assume that the reset is asserted from time zero until the first flag update is requested, so every check starting from a stored-flag value can rely on reset having cleared that value. To meet these assumptions, the stimulus changes inputs only on the falling edge, holds setFlags low during reset and drives every input to a defined value before reset is released.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND   = 4'd0,
    OP_OR    = 4'd1,
    OP_XOR   = 4'd2,
    OP_ADD   = 4'd3,
    OP_ADDC  = 4'd4,
    OP_SUB   = 4'd5,
    OP_SUBC  = 4'd6,
    OP_RSUB  = 4'd7,
    OP_RSUBC = 4'd8,
    OP_SRL   = 4'd9,
    OP_SRA   = 4'd10,
    OP_SLL   = 4'd11
  } aluOp_e;

  typedef enum logic [1:0] {
    UNIT_NONE  = 2'd0,
    UNIT_LOGIC = 2'd1,
    UNIT_ARITH = 2'd2,
    UNIT_SHIFT = 2'd3
  } unitSel_e;

  typedef enum logic [1:0] {
    LOGIC_AND = 2'd0,
    LOGIC_OR  = 2'd1,
    LOGIC_XOR = 2'd2
  } logicFn_e;

  typedef enum logic [1:0] {
    SHIFT_RL = 2'd0,
    SHIFT_RA = 2'd1,
    SHIFT_LL = 2'd2
  } shiftFn_e;

  // Strobes from decode to the datapath
  typedef struct packed {
    unitSel_e unitSel;
    logicFn_e logicFn;
    shiftFn_e shiftFn;
    logic     swapOps;   // use B as the first addend / minuend
    logic     negateY;   // invert second operand and add one
    logic     addCarry;  // fold carryIn into the sum
    logic     legal;
  } aluCtrl_t;

  typedef struct packed {
    logic zero;
    logic neg;
    logic ovf;
    logic carry;
  } ccFlags_t;

endpackage

// File: rtl/cc_alu_ctrl.sv
module cc_alu_ctrl
  import cc_alu_pkg::*;
(
  input  logic [3:0] opSel,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl          = '0;
    ctrl.unitSel  = UNIT_NONE;
    ctrl.logicFn  = LOGIC_AND;
    ctrl.shiftFn  = SHIFT_RL;
    case (opSel)
      OP_AND:   begin ctrl.unitSel = UNIT_LOGIC; ctrl.logicFn = LOGIC_AND; ctrl.legal = 1'b1; end
      OP_OR:    begin ctrl.unitSel = UNIT_LOGIC; ctrl.logicFn = LOGIC_OR;  ctrl.legal = 1'b1; end
      OP_XOR:   begin ctrl.unitSel = UNIT_LOGIC; ctrl.logicFn = LOGIC_XOR; ctrl.legal = 1'b1; end
      OP_ADD:   begin ctrl.unitSel = UNIT_ARITH; ctrl.legal = 1'b1; end
      OP_ADDC:  begin ctrl.unitSel = UNIT_ARITH; ctrl.addCarry = 1'b1; ctrl.legal = 1'b1; end
      OP_SUB:   begin ctrl.unitSel = UNIT_ARITH; ctrl.negateY = 1'b1; ctrl.legal = 1'b1; end
      OP_SUBC:  begin
        ctrl.unitSel = UNIT_ARITH; ctrl.negateY = 1'b1; ctrl.addCarry = 1'b1; ctrl.legal = 1'b1;
      end
      OP_RSUB:  begin
        ctrl.unitSel = UNIT_ARITH; ctrl.swapOps = 1'b1; ctrl.negateY = 1'b1; ctrl.legal = 1'b1;
      end
      OP_RSUBC: begin
        ctrl.unitSel = UNIT_ARITH; ctrl.swapOps = 1'b1; ctrl.negateY = 1'b1;
        ctrl.addCarry = 1'b1; ctrl.legal = 1'b1;
      end
      OP_SRL:   begin ctrl.unitSel = UNIT_SHIFT; ctrl.shiftFn = SHIFT_RL; ctrl.legal = 1'b1; end
      OP_SRA:   begin ctrl.unitSel = UNIT_SHIFT; ctrl.shiftFn = SHIFT_RA; ctrl.legal = 1'b1; end
      OP_SLL:   begin ctrl.unitSel = UNIT_SHIFT; ctrl.shiftFn = SHIFT_LL; ctrl.legal = 1'b1; end
      default:  ctrl.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/cc_alu_shift.sv
module cc_alu_shift
  import cc_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] value,
  input  logic [SHW-1:0]   amount,
  input  shiftFn_e         shiftFn,
  output logic [WIDTH-1:0] shifted
);

  function automatic logic [WIDTH-1:0] bitRev(input logic [WIDTH-1:0] x);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) r[i] = x[WIDTH-1-i];
    return r;
  endfunction

  logic             isLeft;
  logic             fillBit;
  logic [WIDTH-1:0] stage [SHW+1];

  assign isLeft   = (shiftFn == SHIFT_LL);
  assign fillBit  = (shiftFn == SHIFT_RA) ? value[WIDTH-1] : 1'b0;
  // Left shift reuses the right shifter on the bit-reversed word
  assign stage[0] = isLeft ? bitRev(value) : value;

  for (genvar gi = 0; gi < SHW; gi++) begin : g_stage
    localparam int STEP = 1 << gi;
    assign stage[gi+1] = amount[gi] ? {{STEP{fillBit}}, stage[gi][WIDTH-1:STEP]} : stage[gi];
  end

  assign shifted = isLeft ? bitRev(stage[SHW]) : stage[SHW];

endmodule

// File: rtl/cc_alu_dp.sv
module cc_alu_dp
  import cc_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  aluCtrl_t         ctrl,
  output logic [WIDTH-1:0] result,
  output ccFlags_t         nextFlags
);

  logic [WIDTH-1:0] xOp, yOp, yEff;
  logic [1:0]       incr;
  logic [WIDTH+1:0] uSum;
  logic [1:0]       sTop;
  logic             arithOvf, arithCarry;
  logic [WIDTH-1:0] logicRes, shiftRes;

  // One shared adder: swap for reverse forms, invert plus one for subtraction
  assign xOp  = ctrl.swapOps ? opB : opA;
  assign yOp  = ctrl.swapOps ? opA : opB;
  assign yEff = ctrl.negateY ? ~yOp : yOp;
  assign incr = {1'b0, ctrl.negateY} + {1'b0, ctrl.addCarry & carryIn};
  assign uSum = {2'b00, xOp} + {2'b00, yEff} + {{WIDTH{1'b0}}, incr};

  // Top two bits of the sign-extended sum, built from the unsigned carry-out
  assign sTop = {2{xOp[WIDTH-1]}} + {2{yEff[WIDTH-1]}} + uSum[WIDTH+1:WIDTH];

  assign arithCarry = |uSum[WIDTH+1:WIDTH];
  assign arithOvf   = !(((sTop == 2'b00) && !uSum[WIDTH-1]) ||
                        ((sTop == 2'b11) &&  uSum[WIDTH-1]));

  always_comb begin
    case (ctrl.logicFn)
      LOGIC_OR:  logicRes = opA | opB;
      LOGIC_XOR: logicRes = opA ^ opB;
      default:   logicRes = opA & opB;
    endcase
  end

  cc_alu_shift #(.WIDTH(WIDTH)) i_shift (
    .value   (opA),
    .amount  (opB[SHW-1:0]),
    .shiftFn (ctrl.shiftFn),
    .shifted (shiftRes)
  );

  always_comb begin
    nextFlags = '0;
    case (ctrl.unitSel)
      UNIT_LOGIC: result = logicRes;
      UNIT_ARITH: begin
        result          = uSum[WIDTH-1:0];
        nextFlags.ovf   = arithOvf;
        nextFlags.carry = arithCarry;
      end
      UNIT_SHIFT: result = shiftRes;
      default:    result = '0;
    endcase
    nextFlags.zero = (result == '0);
    nextFlags.neg  = result[WIDTH-1];
  end

endmodule

// File: rtl/cc_alu_flags.sv
module cc_alu_flags
  import cc_alu_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     load,
  input  ccFlags_t nextFlags,
  output ccFlags_t flags
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     flags <= '0;
    else if (load) flags <= nextFlags;
  end

endmodule

// File: rtl/cc_alu.sv
module cc_alu
  import cc_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [3:0]       opSel,
  input  logic             carryIn,
  input  logic             setFlags,
  output logic [WIDTH-1:0] result,
  output logic             illegalOp,
  output logic             flagZero,
  output logic             flagNeg,
  output logic             flagOvf,
  output logic             flagCarry
);

  aluCtrl_t ctrl;
  ccFlags_t nextFlags, flags;

  cc_alu_ctrl i_ctrl (
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  cc_alu_dp #(.WIDTH(WIDTH)) i_dp (
    .opA       (opA),
    .opB       (opB),
    .carryIn   (carryIn),
    .ctrl      (ctrl),
    .result    (result),
    .nextFlags (nextFlags)
  );

  cc_alu_flags i_flags (
    .clk       (clk),
    .rstN      (rstN),
    .load      (setFlags & ctrl.legal),
    .nextFlags (nextFlags),
    .flags     (flags)
  );

  assign illegalOp = !ctrl.legal;
  assign flagZero  = flags.zero;
  assign flagNeg   = flags.neg;
  assign flagOvf   = flags.ovf;
  assign flagCarry = flags.carry;

endmodule

// File: rtl/cc_alu_chk.sv
module cc_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [3:0]       opSel,
  input logic             setFlags,
  input logic [WIDTH-1:0] result,
  input logic             illegalOp,
  input logic             flagZero,
  input logic             flagNeg,
  input logic             flagOvf,
  input logic             flagCarry
);

  logic [WIDTH:0] plainSum;
  logic [3:0]     stored;
  assign plainSum = {1'b0, opA} + {1'b0, opB};
  assign stored   = {flagZero, flagNeg, flagOvf, flagCarry};

  assert_logic_vc_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    (setFlags && opSel <= 4'd2) |=> (!flagOvf && !flagCarry));

  assert_zn_track_R2: assert property (@(posedge clk) disable iff (!rstN)
    (setFlags && opSel <= 4'd11) |=>
      ((flagZero == ($past(result) == '0)) && (flagNeg == $past(result[WIDTH-1]))));

  assert_add_carry_R3: assert property (@(posedge clk) disable iff (!rstN)
    (setFlags && opSel == 4'd3) |=> (flagCarry == $past(plainSum[WIDTH])));

  assert_sub_noborrow_R4: assert property (@(posedge clk) disable iff (!rstN)
    (setFlags && opSel == 4'd5) |=> (flagCarry == $past(opA >= opB)));

  assert_shift_vc_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (setFlags && opSel >= 4'd9 && opSel <= 4'd11) |=> (!flagOvf && !flagCarry));

  assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !setFlags |=> $stable(stored));

  assert_illegal_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (opSel >= 4'd12) |-> (illegalOp && result == '0));

  assert_illegal_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (opSel >= 4'd12) |=> $stable(stored));

endmodule

bind cc_alu cc_alu_chk #(.WIDTH(WIDTH)) i_cc_alu_chk (
  .clk       (clk),
  .rstN      (rstN),
  .opA       (opA),
  .opB       (opB),
  .opSel     (opSel),
  .setFlags  (setFlags),
  .result    (result),
  .illegalOp (illegalOp),
  .flagZero  (flagZero),
  .flagNeg   (flagNeg),
  .flagOvf   (flagOvf),
  .flagCarry (flagCarry)
);

// File: tb/test_cc_alu.sv
module test_cc_alu;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 19;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [3:0]  opSel = '0;
  logic        carryIn = 1'b0;
  logic        setFlags = 1'b0;
  logic [31:0] result;
  logic        illegalOp, flagZero, flagNeg, flagOvf, flagCarry;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_alu i_cc_alu (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opSel(opSel),
    .carryIn(carryIn), .setFlags(setFlags), .result(result),
    .illegalOp(illegalOp), .flagZero(flagZero), .flagNeg(flagNeg),
    .flagOvf(flagOvf), .flagCarry(flagCarry)
  );

  // {op[3:0], cin, A[31:0], B[31:0], expected result[31:0], expected {Z,N,V,C}}
  localparam logic [104:0] VECS [NVEC] = '{
    {4'd0,  1'b0, 32'hF0F0F0F0, 32'h0F0F0F0F, 32'h00000000, 4'b1000},
    {4'd1,  1'b0, 32'h80000000, 32'h00000001, 32'h80000001, 4'b0100},
    {4'd2,  1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 4'b1000},
    {4'd3,  1'b0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 4'b0110},
    {4'd3,  1'b0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 4'b1001},
    {4'd4,  1'b1, 32'h00000005, 32'h00000003, 32'h00000009, 4'b0000},
    {4'd4,  1'b1, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 4'b1001},
    {4'd5,  1'b0, 32'h00000005, 32'h00000003, 32'h00000002, 4'b0001},
    {4'd5,  1'b0, 32'h00000003, 32'h00000005, 32'hFFFFFFFE, 4'b0100},
    {4'd5,  1'b0, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 4'b0011},
    {4'd6,  1'b1, 32'h00000003, 32'h00000005, 32'hFFFFFFFF, 4'b0100},
    {4'd6,  1'b1, 32'h00000004, 32'h00000005, 32'h00000000, 4'b1001},
    {4'd7,  1'b0, 32'h00000003, 32'h00000005, 32'h00000002, 4'b0001},
    {4'd8,  1'b0, 32'h00000005, 32'h00000003, 32'hFFFFFFFE, 4'b0100},
    {4'd9,  1'b0, 32'h80000000, 32'h0000001F, 32'h00000001, 4'b0000},
    {4'd10, 1'b0, 32'h80000000, 32'h00000004, 32'hF8000000, 4'b0100},
    {4'd11, 1'b0, 32'h00000001, 32'h0000001F, 32'h80000000, 4'b0100},
    {4'd11, 1'b0, 32'h00000003, 32'h00000021, 32'h00000006, 4'b0000},
    {4'd10, 1'b0, 32'h80000001, 32'h00000000, 32'h80000001, 4'b0100}
  };

  function automatic string reqOf(input logic [3:0] op);
    if (op <= 4'd2) return "R1";
    if (op <= 4'd4) return "R3";
    if (op == 4'd5) return "R4";
    if (op == 4'd6) return "R5";
    if (op <= 4'd8) return "R6";
    return "R7";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] flagsNow();
    return {flagZero, flagNeg, flagOvf, flagCarry};
  endfunction

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [3:0] fl;
    // R10: reset clears the stored flags
    repeat (2) @(negedge clk);
    check(flagsNow() == 4'b0000, "R10", "flags in reset", {28'b0, flagsNow()}, 32'h0);
    rstN = 1'b1;

    // Table walk: result checked combinationally, flags after the next edge
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      opSel    = VECS[i][104:101];
      carryIn  = VECS[i][100];
      opA      = VECS[i][99:68];
      opB      = VECS[i][67:36];
      setFlags = 1'b1;
      #1;
      check(result == VECS[i][35:4], reqOf(opSel), $sformatf("result vec %0d", i),
            result, VECS[i][35:4]);
      check(!illegalOp, "R9", $sformatf("illegalOp low vec %0d", i), {31'b0, illegalOp}, 32'h0);
      @(negedge clk);
      fl = flagsNow();
      check(fl[3:2] == VECS[i][3:2], "R2", $sformatf("Z,N vec %0d", i),
            {30'b0, fl[3:2]}, {30'b0, VECS[i][3:2]});
      check(fl[1:0] == VECS[i][1:0], reqOf(opSel), $sformatf("V,C vec %0d", i),
            {30'b0, fl[1:0]}, {30'b0, VECS[i][1:0]});
    end

    // R8: setFlags low, flags stay at 0100 from the last vector
    @(negedge clk);
    opSel = 4'd3; opA = 32'hFFFFFFFF; opB = 32'h00000001; carryIn = 1'b0; setFlags = 1'b0;
    #1;
    check(result == 32'h0, "R3", "add wrap result without setFlags", result, 32'h0);
    @(negedge clk);
    check(flagsNow() == 4'b0100, "R8", "flags held without setFlags",
          {28'b0, flagsNow()}, 32'h4);

    // R9: undefined codes with setFlags high
    @(negedge clk);
    opSel = 4'd12; opA = 32'hFFFFFFFF; opB = 32'h00000001; setFlags = 1'b1;
    #1;
    check(result == 32'h0, "R9", "code 12 result", result, 32'h0);
    check(illegalOp, "R9", "code 12 illegalOp", {31'b0, illegalOp}, 32'h1);
    @(negedge clk);
    check(flagsNow() == 4'b0100, "R9", "flags held on code 12",
          {28'b0, flagsNow()}, 32'h4);
    opSel = 4'd15;
    #1;
    check(result == 32'h0 && illegalOp, "R9", "code 15 result", result, 32'h0);
    @(negedge clk);
    check(flagsNow() == 4'b0100, "R9", "flags held on code 15",
          {28'b0, flagsNow()}, 32'h4);

    // R8: flags load again once a legal op is requested (0 AND 0 -> Z only)
    opSel = 4'd0; opA = 32'h0; opB = 32'h0;
    @(negedge clk);
    check(flagsNow() == 4'b1000, "R8", "flags load on legal op",
          {28'b0, flagsNow()}, 32'h8);

    // R10: a reset in the middle of a run clears the flags
    setFlags = 1'b0;
    rstN = 1'b0;
    #1;
    check(flagsNow() == 4'b0000, "R10", "flags after mid-run reset",
          {28'b0, flagsNow()}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    finishRun();
  end

endmodule